// File: doc/BRIEF.md
# Flash Programming Sequencer with Data Polling

This block is a behavioural model of the parallel programming controller for a small on-chip code flash. An external programmer drives an address, a data byte, a three-bit operation select and an active-low program strobe. The block sequences byte writes, lock-bit writes and whole-array erases. It reports progress on a ready flag and returns array contents, polling status or identification bytes on a read bus.

Byte and lock writes are started by one falling edge of the strobe. They then time themselves over a parameterised number of clock cycles. Programming can only clear bits, so restoring ones takes a full erase. A full erase only takes effect when the strobe is held low for a long parameterised window. Once either of the first two lock bits is programmed, the array contents are hidden from the read bus. All timings are in clock cycles, so a bench or an integrator can scale them.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset every byte reads FFh in read mode, `ready` is 1 and `erase_err` is 0. All three lock bits start unprogrammed.
- R2: A falling edge on `prog_n` that is sampled on a rising clock edge starts a byte write when two conditions hold: `ready` is 1 and `mode` is write. `ready` is then low for exactly WRITE_CYCLES cycles, starting with the cycle after that edge. The same timing applies to lock writes.
- R3: A byte write stores the bitwise AND of the old byte and the presented byte. Writing a value that has ones where the stored byte has zeros leaves those bits at zero.
- R4: During a byte write, a read-mode access to the address being written returns the presented byte with bit 7 inverted. From the cycle in which `ready` is back at 1, the read returns the true stored byte on all bits.
- R5: Falling edges of `prog_n` while `ready` is 0 are ignored. They cause no second write, and they do not lengthen the busy period.
- R6: In erase mode, `prog_n` may be held low for ERASE_CYCLES consecutive sampled edges. This sets every byte to FFh and returns all lock bits to unprogrammed. `ready` is 0 from the cycle after the falling edge until the cycle after `prog_n` is released.
- R7: If `prog_n` is released before that window ends, the erase is aborted. The array and the lock bits are unchanged, and `erase_err` becomes 1. The flag is cleared when the next write, lock write or erase starts.
- R8: In lock mode, a strobe programs the lock bit selected by `addr[1:0]`: 0 selects the first lock bit, 1 the second and 2 the third. The value 3 has no effect.
- R9: While the first or second lock bit is programmed, read mode returns FFh at every address. The third lock bit alone does not hide data.
- R10: Signature mode returns fixed bytes regardless of lock state. Address 030h gives 1Eh and 031h gives 51h. Address 032h gives FFh when HIGH_VPP=1 and 05h when HIGH_VPP=0. Any other address gives FFh.
- R11: The `mode` encoding is 0 none, 1 byte write, 2 read, 3 erase, 4 lock write and 5 signature; 6 and 7 act as none. In every mode other than read and signature, `rdata` is FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operation select (encoding in R11) |
| addr | input | ADDR_W | Byte address, lock select or signature address |
| wdata | input | 8 | Byte presented for programming |
| prog_n | input | 1 | Active-low program / erase strobe |
| rdata | output | 8 | Read-back, polling or signature byte |
| ready | output | 1 | 1 when idle, 0 while an operation is in progress |
| erase_err | output | 1 | Set by an aborted erase |

## Verification
The hardest case to reach is the erase window boundary. The strobe must be held low for exactly one edge fewer than the erase needs, and then for exactly the full count. The stimulus counts falling clock edges while the strobe is low and releases it on a chosen edge. This shows that the abort leaves old data visible and raises the error flag. The polling read is also timed by edge counting. The read mux is switched to the written address on the very edge where the strobe is released, so the inverted top bit is seen inside the busy window. A second strobe is then dropped mid-write to show that the busy length is unchanged.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int BYTE_W = 8;
    localparam int NLOCK  = 3;

    typedef enum logic [2:0] {
        MODE_NONE  = 3'd0,
        MODE_WRITE = 3'd1,
        MODE_READ  = 3'd2,
        MODE_ERASE = 3'd3,
        MODE_LOCK  = 3'd4,
        MODE_SIG   = 3'd5
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_LOCK,
        ST_EHOLD,
        ST_EDONE
    } state_e;

    // One-cycle commit strobes from the sequencer to the storage
    typedef struct packed {
        logic store;
        logic lock;
        logic wipe;
    } commit_t;

    // Status byte seen while a byte write is in flight
    function automatic logic [BYTE_W-1:0] poll_byte(input logic [BYTE_W-1:0] d);
        return {~d[BYTE_W-1], d[BYTE_W-2:0]};
    endfunction

    // Identification bytes, selected by the low address byte
    function automatic logic [BYTE_W-1:0] sig_byte(input logic [7:0] lo, input logic hv);
        logic [BYTE_W-1:0] r;
        case (lo)
            8'h30:   r = 8'h1E;
            8'h31:   r = 8'h51;
            8'h32:   r = hv ? 8'hFF : 8'h05;
            default: r = 8'hFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fps_edge.sv
module fps_edge (
    input  logic clk,
    input  logic rst,
    input  logic pulse_n,
    output logic fall
);
    logic pn_q;

    always_ff @(posedge clk) begin
        if (rst) pn_q <= 1'b1;
        else     pn_q <= pulse_n;
    end

    assign fall = pn_q & ~pulse_n;
endmodule

// File: rtl/fps_seq.sv
module fps_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 300000,
    parameter int ERASE_CYCLES = 2000000   // must be 2 or more
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              fall,
    input  logic              pulse_n,
    output state_e            state,
    output commit_t           act,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [BYTE_W-1:0] lat_data,
    output logic              erase_err
);
    localparam int MAXC  = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] W_LAST = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            lat_addr  <= '0;
            lat_data  <= '0;
            erase_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        case (mode)
                            MODE_WRITE, MODE_LOCK: begin
                                state     <= (mode == MODE_WRITE) ? ST_WRITE : ST_LOCK;
                                cnt       <= '0;
                                lat_addr  <= addr;
                                lat_data  <= wdata;
                                erase_err <= 1'b0;
                            end
                            MODE_ERASE: begin
                                state     <= ST_EHOLD;
                                cnt       <= CNT_W'(1);
                                erase_err <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WRITE, ST_LOCK: begin
                    if (cnt == W_LAST) state <= ST_IDLE;
                    else               cnt   <= cnt + 1'b1;
                end
                ST_EHOLD: begin
                    if (pulse_n) begin
                        state     <= ST_IDLE;
                        erase_err <= 1'b1;
                    end else if (cnt == E_LAST) begin
                        state <= ST_EDONE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_EDONE: begin
                    if (pulse_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        act.store = (state == ST_WRITE) && (cnt == W_LAST);
        act.lock  = (state == ST_LOCK)  && (cnt == W_LAST);
        act.wipe  = (state == ST_EHOLD) && !pulse_n && (cnt == E_LAST);
    end
endmodule

// File: rtl/fps_array.sv
module fps_array
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter bit HIGH_VPP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  commit_t           act,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [BYTE_W-1:0] lat_data,
    input  logic              wr_busy,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [NLOCK-1:0]  lock_n;     // 1 = unprogrammed
    logic              sig_hit;
    logic              hidden;

    always_ff @(posedge clk) begin
        if (rst || act.wipe) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            lock_n <= '1;
        end else begin
            if (act.store)
                mem[lat_addr] <= mem[lat_addr] & lat_data;
            if (act.lock && (lat_addr[1:0] != 2'b11))
                lock_n[lat_addr[1:0]] <= 1'b0;
        end
    end

    assign sig_hit = ((addr >> 8) == '0);
    assign hidden  = !lock_n[0] || !lock_n[1];

    always_comb begin
        rdata = '1;
        case (mode)
            MODE_SIG: begin
                if (sig_hit) rdata = sig_byte(addr[7:0], HIGH_VPP);
            end
            MODE_READ: begin
                if (wr_busy && (addr == lat_addr)) rdata = poll_byte(lat_data);
                else if (!hidden)                  rdata = mem[addr];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 300000,
    parameter int ERASE_CYCLES = 2000000,
    parameter bit HIGH_VPP     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              prog_n,
    output logic [7:0]        rdata,
    output logic              ready,
    output logic              erase_err
);
    mode_e             mode_q;
    state_e            state;
    commit_t           act;
    logic              fall;
    logic [ADDR_W-1:0] lat_addr;
    logic [BYTE_W-1:0] lat_data;

    assign mode_q = mode_e'(mode);

    fps_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .pulse_n (prog_n),
        .fall    (fall)
    );

    fps_seq #(
        .ADDR_W       (ADDR_W),
        .WRITE_CYCLES (WRITE_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .addr      (addr),
        .wdata     (wdata),
        .fall      (fall),
        .pulse_n   (prog_n),
        .state     (state),
        .act       (act),
        .lat_addr  (lat_addr),
        .lat_data  (lat_data),
        .erase_err (erase_err)
    );

    fps_array #(
        .ADDR_W   (ADDR_W),
        .HIGH_VPP (HIGH_VPP)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .lat_addr (lat_addr),
        .lat_data (lat_data),
        .wr_busy  (state == ST_WRITE),
        .mode     (mode_q),
        .addr     (addr),
        .rdata    (rdata)
    );

    assign ready = (state == ST_IDLE);
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int ADDR_W       = 12,
    parameter int WRITE_CYCLES = 300000,
    parameter bit HIGH_VPP     = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        mode,
    input logic [ADDR_W-1:0] addr,
    input logic              prog_n,
    input logic [7:0]        rdata,
    input logic              ready,
    input logic              erase_err
);
    logic        prev_pn;
    logic        in_wr;
    int unsigned wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_pn <= 1'b1;
            in_wr   <= 1'b0;
            wcnt    <= 0;
        end else begin
            prev_pn <= prog_n;
            if (!in_wr) begin
                if (prev_pn && !prog_n && ready && (mode == 3'd1 || mode == 3'd4)) begin
                    in_wr <= 1'b1;
                    wcnt  <= 0;
                end
            end else if (ready) begin
                in_wr <= 1'b0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // R2: busy window of a write lasts exactly WRITE_CYCLES
    assert_busy_length_R2: assert property (@(posedge clk) disable iff (rst)
        in_wr |-> (ready ? (wcnt == WRITE_CYCLES) : (wcnt < WRITE_CYCLES)));

    // R2: ready only drops right after a sampled strobe fall
    assert_ready_fall_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> (!$past(prog_n) && $past(prog_n, 2)));

    // R7: error flag only rises after the strobe is released
    assert_abort_flag_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_err) |-> ($past(prog_n) && !$past(prog_n, 2)));

    // R10: identification bytes
    assert_sig_maker_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 && addr == ADDR_W'(12'h030)) |-> (rdata == 8'h1E));

    assert_sig_volt_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 && addr == ADDR_W'(12'h032)) |-> (rdata == (HIGH_VPP ? 8'hFF : 8'h05)));

    // R11: non-reading modes drive all ones
    assert_idle_modes_ff_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode == 3'd1 || mode == 3'd3 || mode == 3'd4) |-> (rdata == 8'hFF));
endmodule

bind flash_prog_seq fps_checker #(
    .ADDR_W       (ADDR_W),
    .WRITE_CYCLES (WRITE_CYCLES),
    .HIGH_VPP     (HIGH_VPP)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .addr      (addr),
    .prog_n    (prog_n),
    .rdata     (rdata),
    .ready     (ready),
    .erase_err (erase_err)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/100ps
module flash_prog_seq_bench;
    localparam int TB_W = 20;
    localparam int TB_E = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_r = 3'd0;
    logic [11:0] addr_r = '0;
    logic [7:0]  wdata_r = '0;
    logic        prog_n_r = 1'b1;
    logic [7:0]  rdata;
    logic        ready;
    logic        erase_err;

    int n_checks = 0;
    int n_fail   = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    flash_prog_seq #(
        .ADDR_W       (12),
        .WRITE_CYCLES (TB_W),
        .ERASE_CYCLES (TB_E),
        .HIGH_VPP     (1'b1)
    ) u_flash_prog_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_r),
        .addr      (addr_r),
        .wdata     (wdata_r),
        .prog_n    (prog_n_r),
        .rdata     (rdata),
        .ready     (ready),
        .erase_err (erase_err)
    );

    // monitor: compares queued expectations 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [9:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({rdata, ready, erase_err} !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual rd=%h rdy=%b err=%b expected rd=%h rdy=%b err=%b",
                             t, rdata, ready, erase_err, e[9:2], e[1], e[0]);
                end
            end
        end
    end

    task automatic push(input logic [7:0] rd, input logic rdy, input logic er, input string tag);
        exp_q.push_back({rd, rdy, er});
        tag_q.push_back(tag);
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic look(input logic [2:0] m, input logic [11:0] a, input logic [7:0] rd,
                        input logic rdy, input logic er, input string tag);
        @(negedge clk);
        mode_r = m;
        addr_r = a;
        push(rd, rdy, er, tag);
    endtask

    task automatic busy_count(inout int n);
        @(negedge clk);
        while (!ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d, input logic [7:0] true_v,
                            input string tag_poll, input string tag_true);
        int n;
        @(negedge clk);
        mode_r = 3'd1; addr_r = a; wdata_r = d; prog_n_r = 1'b0;
        @(negedge clk);
        prog_n_r = 1'b1;
        mode_r   = 3'd2;
        push({~d[7], d[6:0]}, 1'b0, 1'b0, tag_poll);
        n = 1;
        busy_count(n);
        chk_int("R2 write busy cycles", n, TB_W);
        push(true_v, 1'b1, 1'b0, tag_true);
    endtask

    task automatic do_lock(input logic [11:0] sel);
        int n;
        @(negedge clk);
        mode_r = 3'd4; addr_r = sel; prog_n_r = 1'b0;
        @(negedge clk);
        prog_n_r = 1'b1;
        mode_r   = 3'd0;
        push(8'hFF, 1'b0, 1'b0, "R8 lock write busy");
        n = 1;
        busy_count(n);
        chk_int("R8 lock busy cycles", n, TB_W);
    endtask

    task automatic erase_hold(input int n_low, input string tag);
        @(negedge clk);
        mode_r = 3'd3; prog_n_r = 1'b0;
        @(negedge clk);
        push(8'hFF, 1'b0, 1'b0, "R6 ready low during erase hold");
        repeat (n_low - 1) @(negedge clk);
        push(8'hFF, 1'b0, 1'b0, tag);
        prog_n_r = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        look(3'd2, 12'h000, 8'hFF, 1'b1, 1'b0, "R1 erased byte 000");
        look(3'd2, 12'h123, 8'hFF, 1'b1, 1'b0, "R1 erased byte 123");
        look(3'd2, 12'hFFF, 8'hFF, 1'b1, 1'b0, "R1 erased byte FFF");

        // R11 non-reading modes
        look(3'd0, 12'h123, 8'hFF, 1'b1, 1'b0, "R11 mode none");
        look(3'd6, 12'h030, 8'hFF, 1'b1, 1'b0, "R11 mode 6");

        // R10 signature
        look(3'd5, 12'h030, 8'h1E, 1'b1, 1'b0, "R10 sig 030");
        look(3'd5, 12'h031, 8'h51, 1'b1, 1'b0, "R10 sig 031");
        look(3'd5, 12'h032, 8'hFF, 1'b1, 1'b0, "R10 sig 032");
        look(3'd5, 12'h033, 8'hFF, 1'b1, 1'b0, "R10 sig other");
        look(3'd5, 12'h130, 8'hFF, 1'b1, 1'b0, "R10 sig upper bits");

        // R2 / R4 first write, R3 overwrite rules
        do_write(12'h123, 8'h5A, 8'h5A, "R4 poll 5A", "R4 true 5A");
        do_write(12'h123, 8'hA5, 8'h00, "R4 poll A5", "R3 AND gives 00");
        do_write(12'h124, 8'hF0, 8'hF0, "R4 poll F0", "R4 true F0");
        do_write(12'h124, 8'h3C, 8'h30, "R4 poll 3C", "R3 AND gives 30");

        // R5 strobe during busy is ignored
        @(negedge clk);
        mode_r = 3'd1; addr_r = 12'h300; wdata_r = 8'h0F; prog_n_r = 1'b0;
        @(negedge clk);
        prog_n_r = 1'b1;
        push(8'hFF, 1'b0, 1'b0, "R11 write mode reads FF while busy");
        @(negedge clk);
        addr_r = 12'h301; wdata_r = 8'h00; prog_n_r = 1'b0;
        @(negedge clk);
        prog_n_r = 1'b1;
        mode_r   = 3'd2;
        push(8'hFF, 1'b0, 1'b0, "R5 second strobe not taken");
        n = 3;
        busy_count(n);
        chk_int("R5 busy not extended", n, TB_W);
        look(3'd2, 12'h301, 8'hFF, 1'b1, 1'b0, "R5 intruding byte untouched");
        look(3'd2, 12'h300, 8'h0F, 1'b1, 1'b0, "R5 original write stored");

        // R7 aborted erase
        erase_hold(TB_E - 1, "R7 hold one short");
        look(3'd2, 12'h123, 8'h00, 1'b1, 1'b1, "R7 abort keeps array, sets flag");
        look(3'd2, 12'h300, 8'h0F, 1'b1, 1'b1, "R7 abort keeps array 300");
        do_write(12'h050, 8'h81, 8'h81, "R7 flag cleared by write start", "R4 true 81");

        // R8 / R9 lock bits
        do_lock(12'h002);
        look(3'd2, 12'h123, 8'h00, 1'b1, 1'b0, "R9 third lock bit alone keeps data");
        do_lock(12'h003);
        look(3'd2, 12'h124, 8'h30, 1'b1, 1'b0, "R8 select 3 has no effect");
        do_lock(12'h001);
        look(3'd2, 12'h124, 8'hFF, 1'b1, 1'b0, "R9 second lock bit hides data");
        look(3'd2, 12'h050, 8'hFF, 1'b1, 1'b0, "R9 hidden at 050");
        look(3'd5, 12'h031, 8'h51, 1'b1, 1'b0, "R10 sig with lock");

        // R6 full erase
        erase_hold(TB_E, "R6 ready low until release");
        look(3'd2, 12'h124, 8'hFF, 1'b1, 1'b0, "R6 array erased");
        do_write(12'h050, 8'h7E, 8'h7E, "R4 poll 7E", "R6 lock bits cleared, data visible");
        look(3'd2, 12'h300, 8'hFF, 1'b1, 1'b0, "R6 other byte erased");

        // R11 remaining modes without strobe
        look(3'd1, 12'h050, 8'hFF, 1'b1, 1'b0, "R11 write mode idle");
        look(3'd3, 12'h050, 8'hFF, 1'b1, 1'b0, "R11 erase mode idle");
        look(3'd4, 12'h050, 8'hFF, 1'b1, 1'b0, "R11 lock mode idle");
        look(3'd2, 12'h050, 8'h7E, 1'b1, 1'b0, "R11 read mode back");

        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule